// File: doc/BRIEF.md
# Integer ALU with Serial Booth Multiplier

This unit is the arithmetic core of a small stack processor whose data width is a parameter (8 and 16 bits are the usual builds). It takes two operands and a 4-bit operation select, and produces one result. It covers the Java integer set: add, subtract, negate, left shift, arithmetic right shift, logical right shift, AND, OR and XOR, plus a signed multiply. Every operation except multiply is combinational, so its result appears in the same cycle as its operands.

Multiply is sequential. A one-cycle `start` pulse with the multiply code latches both operands. A radix-2 Booth recoder then retires one multiplier bit per clock, so a product needs exactly `WIDTH` cycles. `busy` is high while the product is being formed. `done` pulses for one cycle when the product is ready. The completed product stays in a holding register and drives `result` whenever the multiply code is selected, until the next multiply finishes or reset clears it.

Top module: `int_alu`

## Requirements
- R1: Add code 0 gives opA+opB and subtract code 1 gives opA−opB, both wrapping modulo 2^WIDTH.
- R2: Negate code 3 gives 0−opA, modulo 2^WIDTH. opB has no effect.
- R3: A multiply (code 2) returns the low WIDTH bits of the signed product of the operands present at the launch edge. Operand changes after launch have no effect.
- R4: `done` goes high exactly WIDTH clock edges after the launch edge and stays high for one cycle only. `busy` is high from the launch edge until the edge that raises `done`.
- R5: A `start` pulse that arrives while `busy` is high is ignored. Neither the product nor the completion time changes.
- R6: Left shift code 4 shifts opA left by opB masked to its low log2(WIDTH) bits, filling with zeros.
- R7: Arithmetic right shift code 5 shifts opA right by the masked amount, filling with copies of opA's top bit.
- R8: Logical right shift code 6 shifts opA right by the masked amount, filling with zeros.
- R9: Codes 7, 8 and 9 give the bitwise AND, OR and XOR of the operands.
- R10: Codes 10 to 15 give a result of zero.
- R11: Reset (active-low `rstN`) clears `busy`, `done` and the held product, including when a multiply is in progress.
- R12: With code 2 selected, `result` shows the held product from the most recent completed multiply until another one completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | WIDTH | First operand; multiplicand; value to shift |
| opB | input | WIDTH | Second operand; multiplier; shift amount |
| opSel | input | 4 | Operation select code |
| start | input | 1 | Launches a multiply when opSel is 2 and the unit is idle |
| result | output | WIDTH | Combinational result, or the held product under code 2 |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when a new product is available |

## Verification
The bench drives every single-cycle code at a falling edge and samples `result` one time unit later in the same cycle, because no register lies on those paths. For a multiply, the launch is the rising edge that samples `start`. `busy` is checked after each of the following WIDTH−1 edges. `done` and the product are checked after the WIDTH-th edge, and the product is checked again one cycle later with `done` low. A second `start` is pulsed in the middle of one multiply to confirm the timing and the value stay the same. A reset is also applied during a multiply.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_MUL  = 4'd2;
  localparam logic [3:0] OP_NEG  = 4'd3;
  localparam logic [3:0] OP_SHL  = 4'd4;
  localparam logic [3:0] OP_SHRA = 4'd5;
  localparam logic [3:0] OP_SHRL = 4'd6;
  localparam logic [3:0] OP_AND  = 4'd7;
  localparam logic [3:0] OP_OR   = 4'd8;
  localparam logic [3:0] OP_XOR  = 4'd9;

  typedef enum logic [2:0] {
    RES_ADDER,
    RES_PRODUCT,
    RES_SHIFT,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_ZERO
  } resSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    loadMul;
    logic    stepMul;
    logic    finishMul;
    logic    addSub;
    logic    negSel;
    logic    shLeft;
    logic    shArith;
    resSel_t resSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/ripple_add_sub.sv
module ripple_add_sub #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sub,
  output logic [N-1:0] sum
);
  logic [N:0]   carry;
  logic [N-1:0] bx;

  assign carry[0] = sub;
  assign bx       = b ^ {N{sub}};

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum[i]     = a[i] ^ bx[i] ^ carry[i];
    assign carry[i+1] = (a[i] & bx[i]) | (carry[i] & (a[i] ^ bx[i]));
  end

  logic unusedCarry;
  assign unusedCarry = carry[N];
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  input  logic             shLeft,
  input  logic             shArith,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] lvlL [SHW+1];
  logic [WIDTH-1:0] lvlR [SHW+1];
  logic             fillBit;

  assign fillBit = shArith & din[WIDTH-1];
  assign lvlL[0] = din;
  assign lvlR[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign lvlL[s+1] = amt[s] ? {lvlL[s][WIDTH-1-STEP:0], {STEP{1'b0}}} : lvlL[s];
    assign lvlR[s+1] = amt[s] ? {{STEP{fillBit}}, lvlR[s][WIDTH-1:STEP]} : lvlR[s];
  end

  assign dout = shLeft ? lvlL[SHW] : lvlR[SHW];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] result
);
  // Single-cycle adder path: negate feeds zero minus opA
  logic [WIDTH-1:0] addA, addB, addSum;
  assign addA = strobes.negSel ? '0  : opA;
  assign addB = strobes.negSel ? opA : opB;

  ripple_add_sub #(.N(WIDTH)) u_addsub (
    .a  (addA),
    .b  (addB),
    .sub(strobes.addSub),
    .sum(addSum)
  );

  logic [WIDTH-1:0] shiftOut;
  barrel_shifter #(.WIDTH(WIDTH)) u_shift (
    .din    (opA),
    .amt    (opB[SHW-1:0]),
    .shLeft (strobes.shLeft),
    .shArith(strobes.shArith),
    .dout   (shiftOut)
  );

  // Serial radix-2 Booth multiplier, accumulator one bit wider than data
  logic [WIDTH-1:0] mulM;
  logic [WIDTH:0]   acc;
  logic [WIDTH-1:0] mulQ;
  logic             qm1;
  logic [WIDTH-1:0] productReg;

  logic [WIDTH:0]   mExt, boothB, boothSum, nextAcc;
  logic [WIDTH-1:0] nextQ;
  logic             boothSub;

  assign mExt     = {mulM[WIDTH-1], mulM};
  assign boothSub = mulQ[0];
  assign boothB   = (mulQ[0] ^ qm1) ? mExt : '0;

  ripple_add_sub #(.N(WIDTH+1)) u_booth (
    .a  (acc),
    .b  (boothB),
    .sub(boothSub),
    .sum(boothSum)
  );

  assign nextAcc = {boothSum[WIDTH], boothSum[WIDTH:1]};
  assign nextQ   = {boothSum[0], mulQ[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulM       <= '0;
      acc        <= '0;
      mulQ       <= '0;
      qm1        <= 1'b0;
      productReg <= '0;
    end else begin
      if (strobes.loadMul) begin
        mulM <= opA;
        acc  <= '0;
        mulQ <= opB;
        qm1  <= 1'b0;
      end else if (strobes.stepMul) begin
        acc  <= nextAcc;
        mulQ <= nextQ;
        qm1  <= mulQ[0];
      end
      if (strobes.finishMul) begin
        productReg <= nextQ;
      end
    end
  end

  always_comb begin
    unique case (strobes.resSel)
      RES_ADDER:   result = addSum;
      RES_PRODUCT: result = productReg;
      RES_SHIFT:   result = shiftOut;
      RES_AND:     result = opA & opB;
      RES_OR:      result = opA | opB;
      RES_XOR:     result = opA ^ opB;
      default:     result = '0;
    endcase
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   opSel,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  logic [CW-1:0] count;
  logic          launch, lastStep;

  assign launch   = start && (opSel == OP_MUL) && !busy;
  assign lastStep = busy && (count == CW'(1));

  always_comb begin
    strobes           = '0;
    strobes.resSel    = RES_ZERO;
    strobes.loadMul   = launch;
    strobes.stepMul   = busy;
    strobes.finishMul = lastStep;
    unique case (opSel)
      OP_ADD:  strobes.resSel = RES_ADDER;
      OP_SUB:  begin strobes.resSel = RES_ADDER; strobes.addSub = 1'b1; end
      OP_NEG:  begin strobes.resSel = RES_ADDER; strobes.addSub = 1'b1; strobes.negSel = 1'b1; end
      OP_MUL:  strobes.resSel = RES_PRODUCT;
      OP_SHL:  begin strobes.resSel = RES_SHIFT; strobes.shLeft = 1'b1; end
      OP_SHRA: begin strobes.resSel = RES_SHIFT; strobes.shArith = 1'b1; end
      OP_SHRL: strobes.resSel = RES_SHIFT;
      OP_AND:  strobes.resSel = RES_AND;
      OP_OR:   strobes.resSel = RES_OR;
      OP_XOR:  strobes.resSel = RES_XOR;
      default: strobes.resSel = RES_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= lastStep;
      if (launch) begin
        busy  <= 1'b1;
        count <= CW'(WIDTH);
      end else if (busy) begin
        count <= count - CW'(1);
        if (lastStep) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  input  logic             start,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             done
);
  ctrlStrobes_t strobes;

  alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opSel  (opSel),
    .start  (start),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .result (result)
  );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opSel,
  input logic             start,
  input logic [WIDTH-1:0] result,
  input logic             busy,
  input logic             done
);
  logic [WIDTH-1:0] capA, capB, capProd;
  logic [CW-1:0]    busyCycles;
  logic             launchSeen;

  assign launchSeen = start && (opSel == 4'd2) && !busy;
  assign capProd    = capA * capB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA       <= '0;
      capB       <= '0;
      busyCycles <= '0;
    end else if (launchSeen) begin
      capA       <= opA;
      capB       <= opB;
      busyCycles <= '0;
    end else if (busy) begin
      busyCycles <= busyCycles + CW'(1);
    end
  end

  // R1: adder path wraps
  a_r1_add_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 4'd0) |-> (result == WIDTH'(opA + opB)));

  // R3: held product equals the low word of the captured operands
  a_r3_product_low: assert property (@(posedge clk) disable iff (!rstN)
    (done && opSel == 4'd2) |-> (result == capProd));

  // R4: completion latency counted independently
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCycles == CW'(WIDTH)));

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: done follows the end of busy
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R5: an accepted launch raises busy
  a_r5_launch_busy: assert property (@(posedge clk) disable iff (!rstN)
    launchSeen |=> busy);

  // R10: undefined codes give zero
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd10) |-> (result == '0));
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .opA   (opA),
  .opB   (opB),
  .opSel (opSel),
  .start (start),
  .result(result),
  .busy  (busy),
  .done  (done)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [3:0]   opSel = 4'd2;
  logic         start = 1'b0;
  logic [W-1:0] result;
  logic         busy, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  int_alu #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .start(start), .result(result), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  16'h7FFF, 16'h0001, 16'h8000, 4'd1},  // R1 add overflow wraps
    '{4'd0,  16'hFFFF, 16'h0002, 16'h0001, 4'd1},  // R1 add carry out dropped
    '{4'd1,  16'h0005, 16'h0007, 16'hFFFE, 4'd1},  // R1 subtract negative
    '{4'd1,  16'h8000, 16'h0001, 16'h7FFF, 4'd1},  // R1 subtract wraps
    '{4'd3,  16'h0001, 16'h1234, 16'hFFFF, 4'd2},  // R2 negate one
    '{4'd3,  16'h8000, 16'hFFFF, 16'h8000, 4'd2},  // R2 negate most negative
    '{4'd4,  16'h0001, 16'h0013, 16'h0008, 4'd6},  // R6 amount masked 19->3
    '{4'd4,  16'h8421, 16'h0004, 16'h4210, 4'd6},  // R6 bits fall off top
    '{4'd5,  16'h8000, 16'h000F, 16'hFFFF, 4'd7},  // R7 sign fill
    '{4'd5,  16'h7F00, 16'h0024, 16'h07F0, 4'd7},  // R7 positive, masked 36->4
    '{4'd6,  16'h8000, 16'h000F, 16'h0001, 4'd8},  // R8 zero fill
    '{4'd6,  16'hF0F0, 16'h0010, 16'hF0F0, 4'd8},  // R8 amount masked 16->0
    '{4'd7,  16'hF0F0, 16'h3C3C, 16'h3030, 4'd9},  // R9 and
    '{4'd8,  16'hF0F0, 16'h3C3C, 16'hFCFC, 4'd9},  // R9 or
    '{4'd9,  16'hF0F0, 16'h3C3C, 16'hCCCC, 4'd9},  // R9 xor
    '{4'd12, 16'hFFFF, 16'hFFFF, 16'h0000, 4'd10}, // R10 unused code
    '{4'd15, 16'h1234, 16'h5678, 16'h0000, 4'd10}  // R10 unused code
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Launch a multiply; optionally pulse start again while busy
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b, input logic retrigger);
    logic [W-1:0] exp;
    exp = a * b;
    @(negedge clk);
    opSel = 4'd2; opA = a; opB = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    opA = 16'hDEAD; opB = 16'hBEEF;  // R3 later operand changes ignored
    for (int k = 0; k < W; k++) begin
      check("R4 busy during multiply", {15'd0, busy}, 16'd1);
      check("R4 no early done", {15'd0, done}, 16'd0);
      if (retrigger && k == 2) begin
        start = 1'b1; opA = 16'h0003; opB = 16'h0003;  // R5 start while busy
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    check("R4 done after WIDTH edges", {15'd0, done}, 16'd1);
    check("R4 busy cleared at done", {15'd0, busy}, 16'd0);
    check(retrigger ? "R5 product unchanged by retrigger" : "R3 signed low product", result, exp);
    @(posedge clk);
    @(negedge clk);
    check("R4 done lasts one cycle", {15'd0, done}, 16'd0);
    check("R12 product held", result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    check("R11 busy in reset", {15'd0, busy}, 16'd0);
    check("R11 done in reset", {15'd0, done}, 16'd0);
    check("R11 product in reset", result, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 product after reset", result, 16'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opSel = VECS[i].op; opA = VECS[i].a; opB = VECS[i].b;
      #1;
      check($sformatf("R%0d table row %0d", VECS[i].req, i), result, VECS[i].exp);
    end

    runMul(16'h0003, 16'h0005, 1'b0);  // R3 small positive
    runMul(16'hFFFD, 16'h0007, 1'b0);  // R3 negative times positive
    runMul(16'h8000, 16'hFFFF, 1'b0);  // R3 most negative times -1
    runMul(16'h7FFF, 16'h7FFF, 1'b0);  // R3 high bits dropped
    runMul(16'h8000, 16'h8000, 1'b0);  // R3 product low word zero
    runMul(16'h0123, 16'hFF9C, 1'b1);  // R5 retrigger ignored

    // R12 other codes do not disturb the held product
    @(negedge clk);
    opSel = 4'd0; opA = 16'h0001; opB = 16'h0002;
    #1 check("R1 add after multiply", result, 16'h0003);
    @(negedge clk);
    opSel = 4'd2;
    #1 check("R12 product after other ops", result, 16'h0123 * 16'hFF9C);

    // R11 reset during a multiply
    @(negedge clk);
    opA = 16'h0011; opB = 16'h0011; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 busy cleared mid multiply", {15'd0, busy}, 16'd0);
    check("R11 product cleared", result, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (W + 2) begin
      @(negedge clk);
      check("R11 no done after abort", {15'd0, done}, 16'd0);
    end

    summary();
  end
endmodule